// File: doc/BRIEF.md
# Overlapping Register Window File

This block is the integer register file of a small load/store core. Every instruction names registers through 5-bit selectors, so software always sees 32 logical registers. Logical registers 0 to 7 are shared by all procedures and always reach the same storage. Logical registers 8 to 31 form a 24-entry window cut from a larger physical array. The array is organised as a ring of eight windows. Each window has three groups of eight: an incoming group, a private group and an outgoing group. The outgoing group of one window is the incoming group of the next one, so a caller can leave arguments in its outgoing registers and the callee finds them in its incoming registers without any copying.

A small controller holds the current-window pointer and a valid bit per window, and moves the window in response to a 2-bit command. A call moves to the next window if that window is free. A return moves back to the previous window if that window still holds a live caller. When either move is refused, the pointer and mask stay as they are and a one-cycle overflow or underflow flag is raised. The controller has three states. In `ST_RUN` no flag is shown. A refused call takes it to `ST_OVF` and a refused return takes it to `ST_UNF`. From any state, the next command decides the next state, so each flag lasts exactly one cycle unless the next command is refused as well. Two read ports are combinational and the single write port updates on the rising clock edge.

Top module: `rwin_regfile`

## Requirements
- R1: During and after reset (active-low `rst_ni`), the window pointer is 0, the valid mask is 8'h01, both flags are 0, and every register reads 0.
- R2: Logical registers 0 to 7 reach the same storage in every window: a value written in one window reads back unchanged in any other window.
- R3: In window w, logical register 8+k (k = 0..23) maps to physical entry 8 + ((16·w + k) mod 128). As a result, logical 24..31 of window w are logical 8..15 of window w+1, and logical 16..23 are private to window w.
- R4: The windows form a ring: the outgoing group (logical 24..31) of window 7 is the incoming group (logical 8..15) of window 0.
- R5: Command 2'b01 (call) with the valid bit of window (w+1) mod 8 clear sets the pointer to that window and sets its valid bit, visible after the next rising edge.
- R6: A call whose target window already has its valid bit set leaves the pointer and mask unchanged and raises `overflow_o` for exactly the one cycle after that edge.
- R7: Command 2'b10 (return) with the valid bit of window (w−1) mod 8 set clears the valid bit of window w and moves the pointer to w−1.
- R8: A return whose target window has its valid bit clear leaves the pointer and mask unchanged and raises `underflow_o` for exactly the one cycle after that edge.
- R9: Commands 2'b00 (none) and 2'b11 (reserved) change neither the pointer, the mask nor any flag.
- R10: A write issued in the same cycle as a call lands in the window that was current before the call.
- R11: The two read ports are combinational and independent: each output follows its own selector within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | Window command: 00 none, 01 call, 10 return, 11 reserved |
| rd_a_sel_i | input | 5 | Logical register for read port A |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_sel_i | input | 5 | Logical register for read port B |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | Write enable |
| wr_sel_i | input | 5 | Logical register to write |
| wr_data_i | input | 32 | Write data |
| win_ptr_o | output | 3 | Current window index |
| win_valid_o | output | 8 | One valid bit per window |
| overflow_o | output | 1 | Refused call, one-cycle pulse |
| underflow_o | output | 1 | Refused return, one-cycle pulse |

## Verification
If the pointer is wrong, every windowed read goes to the wrong storage at once. Arguments then go missing across a call, and private values from another window show up. These effects appear on the read ports in the same cycle as the first access after the faulty move. A wrong valid mask does not show until the next call or return at that ring position. At that command a refused move is accepted, or an accepted one is refused, and the error reaches the pointer and flag outputs one edge later. The bench therefore fills the ring to its limit and then drains it completely. Along the way it checks argument passing in both directions and across the wrap from window 7 to window 0.

// File: rtl/rwf_pkg.sv
package rwf_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_CALL = 2'b01,
        OP_RET  = 2'b10,
        OP_RSVD = 2'b11
    } win_op_e;

    typedef enum logic [1:0] {
        ST_RUN = 2'b00,
        ST_OVF = 2'b01,
        ST_UNF = 2'b10
    } win_state_e;

endpackage

// File: rtl/rwf_map.sv
module rwf_map #(
    parameter int NGLOB = 8,
    parameter int GRP   = 8,
    parameter int NWIN  = 8,
    parameter int SELW  = 5,
    parameter int WPW   = 3,
    parameter int PW    = 8
) (
    input  logic [WPW-1:0]  wp_i,
    input  logic [SELW-1:0] sel_i,
    output logic [PW-1:0]   idx_o
);
    localparam int UNIQ = 2 * GRP;
    localparam int RING = NWIN * UNIQ;

    logic [PW:0] base;
    logic [PW:0] offs;
    logic [PW:0] sum;
    logic [PW:0] wrapped;

    always_comb begin
        base    = (PW+1)'(wp_i) * (PW+1)'(UNIQ);
        offs    = (PW+1)'(sel_i) - (PW+1)'(NGLOB);
        sum     = base + offs;
        wrapped = (sum >= (PW+1)'(RING)) ? (sum - (PW+1)'(RING)) : sum;
        if (sel_i < SELW'(NGLOB)) begin
            idx_o = PW'(sel_i);
        end else begin
            idx_o = PW'(wrapped + (PW+1)'(NGLOB));
        end
    end

endmodule

// File: rtl/rwf_array.sv
module rwf_array #(
    parameter int NPHYS = 136,
    parameter int DW    = 32,
    parameter int PW    = 8,
    parameter int NRD   = 2
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     we_i,
    input  logic [PW-1:0]            widx_i,
    input  logic [DW-1:0]            wdata_i,
    input  logic [NRD-1:0][PW-1:0]   ridx_i,
    output logic [NRD-1:0][DW-1:0]   rdata_o
);
    logic [DW-1:0] mem [NPHYS];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < NPHYS; i++) begin
                mem[i] <= '0;
            end
        end else if (we_i && (widx_i < PW'(NPHYS))) begin
            mem[widx_i] <= wdata_i;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata_o[g] = (ridx_i[g] < PW'(NPHYS)) ? mem[ridx_i[g]] : '0;
    end

endmodule

// File: rtl/rwf_ctrl.sv
module rwf_ctrl
    import rwf_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int WPW  = 3
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  win_op_e         op_i,
    output logic [WPW-1:0]  wp_o,
    output logic [NWIN-1:0] mask_o,
    output logic            ovf_o,
    output logic            unf_o
);
    localparam logic [WPW-1:0] LAST = WPW'(NWIN - 1);

    win_state_e      state_q, state_d;
    logic [WPW-1:0]  wp_q, wp_d;
    logic [NWIN-1:0] mask_q, mask_d;
    logic [WPW-1:0]  tgt_up, tgt_dn;

    always_comb begin
        tgt_up = (wp_q == LAST) ? '0 : wp_q + WPW'(1);
        tgt_dn = (wp_q == '0) ? LAST : wp_q - WPW'(1);
    end

    always_comb begin
        state_d = ST_RUN;
        wp_d    = wp_q;
        mask_d  = mask_q;
        unique case (op_i)
            OP_CALL: begin
                if (mask_q[tgt_up]) begin
                    state_d = ST_OVF;
                end else begin
                    wp_d           = tgt_up;
                    mask_d[tgt_up] = 1'b1;
                end
            end
            OP_RET: begin
                if (!mask_q[tgt_dn]) begin
                    state_d = ST_UNF;
                end else begin
                    mask_d[wp_q] = 1'b0;
                    wp_d         = tgt_dn;
                end
            end
            OP_NONE, OP_RSVD: begin
                state_d = ST_RUN;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_RUN;
            wp_q    <= '0;
            mask_q  <= NWIN'(1);
        end else begin
            state_q <= state_d;
            wp_q    <= wp_d;
            mask_q  <= mask_d;
        end
    end

    always_comb begin
        wp_o   = wp_q;
        mask_o = mask_q;
        ovf_o  = 1'b0;
        unf_o  = 1'b0;
        unique case (state_q)
            ST_OVF:  ovf_o = 1'b1;
            ST_UNF:  unf_o = 1'b1;
            default: begin
                ovf_o = 1'b0;
                unf_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rwin_regfile.sv
module rwin_regfile
    import rwf_pkg::*;
#(
    parameter int DW    = 32,
    parameter int NWIN  = 8,
    parameter int NGLOB = 8,
    parameter int GRP   = 8,
    parameter int SELW  = $clog2(NGLOB + 3 * GRP),
    parameter int WPW   = $clog2(NWIN)
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [1:0]      op_i,
    input  logic [SELW-1:0] rd_a_sel_i,
    output logic [DW-1:0]   rd_a_data_o,
    input  logic [SELW-1:0] rd_b_sel_i,
    output logic [DW-1:0]   rd_b_data_o,
    input  logic            wr_en_i,
    input  logic [SELW-1:0] wr_sel_i,
    input  logic [DW-1:0]   wr_data_i,
    output logic [WPW-1:0]  win_ptr_o,
    output logic [NWIN-1:0] win_valid_o,
    output logic            overflow_o,
    output logic            underflow_o
);
    localparam int NPHYS = NGLOB + NWIN * 2 * GRP;
    localparam int PW    = $clog2(NPHYS);
    localparam int NRD   = 2;
    localparam int NPORT = NRD + 1;

    win_op_e                    op;
    logic [WPW-1:0]             wp;
    logic [NPORT-1:0][SELW-1:0] sel;
    logic [NPORT-1:0][PW-1:0]   idx;
    logic [NRD-1:0][PW-1:0]     ridx;
    logic [NRD-1:0][DW-1:0]     rdata;

    assign op  = win_op_e'(op_i);
    assign sel = {wr_sel_i, rd_b_sel_i, rd_a_sel_i};

    rwf_ctrl #(
        .NWIN (NWIN),
        .WPW  (WPW)
    ) u_ctrl (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .op_i   (op),
        .wp_o   (wp),
        .mask_o (win_valid_o),
        .ovf_o  (overflow_o),
        .unf_o  (underflow_o)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_map
        rwf_map #(
            .NGLOB (NGLOB),
            .GRP   (GRP),
            .NWIN  (NWIN),
            .SELW  (SELW),
            .WPW   (WPW),
            .PW    (PW)
        ) u_map (
            .wp_i  (wp),
            .sel_i (sel[p]),
            .idx_o (idx[p])
        );
    end

    for (genvar r = 0; r < NRD; r++) begin : g_ridx
        assign ridx[r] = idx[r];
    end

    rwf_array #(
        .NPHYS (NPHYS),
        .DW    (DW),
        .PW    (PW),
        .NRD   (NRD)
    ) u_array (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (wr_en_i),
        .widx_i  (idx[NRD]),
        .wdata_i (wr_data_i),
        .ridx_i  (ridx),
        .rdata_o (rdata)
    );

    assign rd_a_data_o = rdata[0];
    assign rd_b_data_o = rdata[1];
    assign win_ptr_o   = wp;

endmodule

// File: rtl/rwf_checker.sv
module rwf_checker #(
    parameter int NWIN = 8,
    parameter int WPW  = 3
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic [1:0]      op_i,
    input logic [WPW-1:0]  win_ptr_o,
    input logic [NWIN-1:0] win_valid_o,
    input logic            overflow_o,
    input logic            underflow_o
);
    logic past_ok;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) past_ok <= 1'b0;
        else         past_ok <= 1'b1;
    end

    AST_CUR_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
        win_valid_o[win_ptr_o]); // R5

    AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(overflow_o && underflow_o)); // R6

    AST_OVF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (past_ok && overflow_o) |-> (win_ptr_o == $past(win_ptr_o)
                                     && win_valid_o == $past(win_valid_o))); // R6

    AST_UNF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (past_ok && underflow_o) |-> (win_ptr_o == $past(win_ptr_o)
                                      && win_valid_o == $past(win_valid_o))); // R8

    AST_CALL_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (past_ok && $past(op_i) == 2'b01 && !overflow_o)
            |-> (win_ptr_o == WPW'((32'($past(win_ptr_o)) + 1) % NWIN))); // R5

    AST_RET_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (past_ok && $past(op_i) == 2'b10 && !underflow_o)
            |-> (win_ptr_o == WPW'((32'($past(win_ptr_o)) + NWIN - 1) % NWIN))); // R7

    AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (past_ok && ($past(op_i) == 2'b00 || $past(op_i) == 2'b11))
            |-> ($stable(win_ptr_o) && $stable(win_valid_o)
                 && !overflow_o && !underflow_o)); // R9

endmodule

bind rwin_regfile rwf_checker #(
    .NWIN (NWIN),
    .WPW  (WPW)
) u_rwf_checker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_i        (op_i),
    .win_ptr_o   (win_ptr_o),
    .win_valid_o (win_valid_o),
    .overflow_o  (overflow_o),
    .underflow_o (underflow_o)
);

// File: tb/test_rwin_regfile.sv
`timescale 1ns/1ps
module test_rwin_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [4:0]  ra_sel = '0, rb_sel = '0, w_sel = '0;
    logic [31:0] ra_dat, rb_dat, w_dat = '0;
    logic        w_en = 1'b0;
    logic [2:0]  ptr;
    logic [7:0]  vmask;
    logic        ovf, unf;

    int checks = 0;
    int fails  = 0;
    int        exp_ptr  = 0;
    logic [7:0] exp_mask = 8'h01;

    always #2 clk = ~clk;

    rwin_regfile i_rwin_regfile (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .op_i        (op),
        .rd_a_sel_i  (ra_sel),
        .rd_a_data_o (ra_dat),
        .rd_b_sel_i  (rb_sel),
        .rd_b_data_o (rb_dat),
        .wr_en_i     (w_en),
        .wr_sel_i    (w_sel),
        .wr_data_i   (w_dat),
        .win_ptr_o   (ptr),
        .win_valid_o (vmask),
        .overflow_o  (ovf),
        .underflow_o (unf)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one clock: drive at negedge, let the posedge pass, return at next negedge
    task automatic step(input logic [1:0] o, input logic we, input logic [4:0] ws,
                        input logic [31:0] wd);
        op = o; w_en = we; w_sel = ws; w_dat = wd;
        @(posedge clk);
        @(negedge clk);
        op = 2'b00; w_en = 1'b0;
    endtask

    function automatic int nxt(input int w);
        return (w + 1) % 8;
    endfunction

    function automatic int prv(input int w);
        return (w + 7) % 8;
    endfunction

    task automatic rd(input logic [4:0] s, output logic [31:0] d);
        ra_sel = s;
        #0.5;
        d = ra_dat;
    endtask

    task automatic check_state(input string req, input logic eo, input logic eu);
        chk({req, " ptr"}, 32'(ptr), 32'(exp_ptr));
        chk({req, " mask"}, 32'(vmask), 32'(exp_mask));
        chk({req, " ovf"}, 32'(ovf), 32'(eo));
        chk({req, " unf"}, 32'(unf), 32'(eu));
    endtask

    task automatic do_call(input string req);
        logic refuse;
        refuse = exp_mask[nxt(exp_ptr)];
        step(2'b01, 1'b0, '0, '0);
        if (!refuse) begin
            exp_ptr = nxt(exp_ptr);
            exp_mask[exp_ptr] = 1'b1;
        end
        check_state(req, refuse, 1'b0);
    endtask

    task automatic do_ret(input string req);
        logic refuse;
        refuse = !exp_mask[prv(exp_ptr)];
        step(2'b10, 1'b0, '0, '0);
        if (!refuse) begin
            exp_mask[exp_ptr] = 1'b0;
            exp_ptr = prv(exp_ptr);
        end
        check_state(req, 1'b0, refuse);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check_state("R1", 1'b0, 1'b0);
        rd(5'd5, d);  chk("R1 global read", d, 32'h0);
        rd(5'd20, d); chk("R1 window read", d, 32'h0);
    endtask

    task automatic t_underflow_at_reset;
        do_ret("R8 return at root");
        step(2'b00, 1'b0, '0, '0);
        check_state("R8 pulse ends", 1'b0, 1'b0);
    endtask

    task automatic t_globals;
        logic [31:0] d;
        step(2'b00, 1'b1, 5'd3, 32'hA1A1_0003);
        do_call("R5 call 0->1");
        rd(5'd3, d); chk("R2 global in window 1", d, 32'hA1A1_0003);
        step(2'b00, 1'b1, 5'd3, 32'hB2B2_0003);
        do_ret("R7 return 1->0");
        rd(5'd3, d); chk("R2 global back in window 0", d, 32'hB2B2_0003);
    endtask

    task automatic t_overlap;
        logic [31:0] d;
        step(2'b00, 1'b1, 5'd26, 32'hC0DE_0026);
        step(2'b00, 1'b1, 5'd18, 32'h1111_0018);
        do_call("R5 call for args");
        rd(5'd10, d); chk("R3 arg seen as incoming", d, 32'hC0DE_0026);
        rd(5'd18, d); chk("R3 local private", d, 32'h0);
        step(2'b00, 1'b1, 5'd10, 32'hBEEF_0010);
        do_ret("R7 return with result");
        rd(5'd26, d); chk("R3 result seen by caller", d, 32'hBEEF_0010);
        rd(5'd18, d); chk("R3 caller local kept", d, 32'h1111_0018);
    endtask

    task automatic t_write_with_call;
        logic [31:0] d;
        step(2'b01, 1'b1, 5'd20, 32'h5A5A_0020);
        exp_ptr = 1; exp_mask[1] = 1'b1;
        check_state("R10 call with write", 1'b0, 1'b0);
        rd(5'd20, d); chk("R10 new window untouched", d, 32'h0);
        do_ret("R7 return after write");
        rd(5'd20, d); chk("R10 write in old window", d, 32'h5A5A_0020);
    endtask

    task automatic t_noop;
        logic [31:0] d;
        step(2'b11, 1'b0, '0, '0);
        check_state("R9 reserved op", 1'b0, 1'b0);
        step(2'b00, 1'b0, '0, '0);
        check_state("R9 none op", 1'b0, 1'b0);
        rd(5'd20, d); chk("R9 data kept", d, 32'h5A5A_0020);
    endtask

    task automatic t_dual_read;
        ra_sel = 5'd3; rb_sel = 5'd20;
        #0.5;
        chk("R11 port A", ra_dat, 32'hB2B2_0003);
        chk("R11 port B", rb_dat, 32'h5A5A_0020);
        ra_sel = 5'd20; rb_sel = 5'd3;
        #0.5;
        chk("R11 port A swapped", ra_dat, 32'h5A5A_0020);
        chk("R11 port B swapped", rb_dat, 32'hB2B2_0003);
    endtask

    task automatic t_fill_and_wrap;
        logic [31:0] d;
        for (int i = 0; i < 7; i++) do_call("R5 fill ring");
        chk("R5 ring full", 32'(vmask), 32'hFF);
        do_call("R6 call into live window");
        step(2'b00, 1'b0, '0, '0);
        check_state("R6 pulse ends", 1'b0, 1'b0);
        step(2'b00, 1'b1, 5'd28, 32'h7777_0028);
        for (int i = 0; i < 7; i++) do_ret("R7 drain ring");
        rd(5'd12, d); chk("R4 window 7 out is window 0 in", d, 32'h7777_0028);
        do_ret("R8 return past root");
    endtask

    initial begin
        #100000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_underflow_at_reset();
        t_globals();
        t_overlap();
        t_write_with_call();
        t_noop();
        t_dual_read();
        t_fill_and_wrap();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule